// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Device Model

This block is a synthesizable model of the device side of an 8192-bit serial memory with a three-wire interface. A host selects the device with a chip-select line, clocks instruction bits in on a serial data input, and reads results back from a serial data output that has its own output-enable. A strap input selects the organization: 512 words of 16 bits, or 1024 bytes. The storage is a register array inside the model. The three serial inputs are brought into the system clock domain through two-flop synchronizers, and all edge detection happens in that domain.

Seven instructions are decoded. Read supports burst operation. Word write, location erase, erase-all and fill-all change the contents only after an unlock command, and stay possible until a lock command or reset. A write-type instruction commits only if chip-select falls in the narrow window after its last bit. A self-timed program cycle of a parameterized number of system clocks then runs. While chip-select is high, the output reports busy or ready. Clocking a 1 into the input releases the output again, so input and output can share one wire.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, ser_oe is low, modifying instructions are locked, and every location reads as all ones.
- R2: A frame is a 1 start bit, then a 2-bit opcode (10 read, 01 write, 11 erase, 00 special), then an address of 10 bits in 16-bit organization or 11 bits in 8-bit organization, sent MSB first. Zeros before the start bit are ignored, and the address MSB does not take part in selecting a location.
- R3: On read, ser_oe rises with ser_out at 0 after the last address bit is sampled. The addressed word then follows MSB first, with one bit per rising ser_clk edge.
- R4: While chip_sel stays high, a read continues with the next location, with no extra 0 between words. After the last location it continues at location 0.
- R5: In the special group, the two address MSBs select the operation: 11 unlock, 00 lock, 10 erase-all, 01 fill-all. When locked, write, erase, erase-all and fill-all leave the contents unchanged and start no program cycle.
- R6: Write stores the data field, 16 or 8 bits MSB first, at the addressed location without a prior erase.
- R7: Erase sets one location to all ones. Erase-all sets every location to all ones. Fill-all writes its data field to every location.
- R8: A program cycle starts only if chip_sel falls after the last required bit is sampled and before the next rising ser_clk. A fall at any other time drops the instruction.
- R9: After a program cycle starts, while chip_sel is high, ser_oe is high and ser_out is 0 for PROG_CYCLES system clocks. After that, ser_out is 1.
- R10: While ready status is shown, a 1 sampled on ser_in drives ser_oe low at the following falling ser_clk edge. That same 1 counts as a start bit.
- R11: While a program cycle runs, ser_clk edges are ignored, so no instruction is decoded.
- R12: With chip_sel low, ser_oe is low and any partly received instruction is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Device select, active high |
| ser_clk | input | 1 | Serial bit clock from host |
| ser_in | input | 1 | Serial instruction/data input |
| wide_org | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| ser_out | output | 1 | Serial read data or ready/busy status |
| ser_oe | output | 1 | Output enable for ser_out |

## Verification
The bench writes distinct, asymmetric word values and reads them back in bursts that start just before the top of the array. This separates correct wrapping and word ordering from address or bit-order slips. Writes are repeated with the lock set and cleared, and with chip-select dropped one bit early or one clock late, so each commit condition is shown to matter on its own. Commands clocked during a busy cycle, and reads with the ignored address MSB set, are compared against unchanged reference contents. Both organizations are exercised, and every output bit is checked against a behavioural reference memory kept in the bench.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int MW_WORD   = 16;
    localparam int MW_AW_MAX = 16;

    typedef enum logic [1:0] {
        OPC_SPEC  = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } mw_opc_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } mw_sub_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [1:0] {
        PK_ONE,
        PK_CLR,
        PK_FILL,
        PK_WIPE
    } mw_kind_e;

    typedef struct packed {
        mw_kind_e               kind;
        logic                   wide;
        logic [MW_AW_MAX-1:0]   addr;
        logic [MW_WORD-1:0]     data;
    } mw_prog_t;

    // does a program request touch byte index idx
    function automatic logic mw_hit(mw_prog_t p, int unsigned idx);
        logic h;
        case (p.kind)
            PK_FILL, PK_WIPE: h = 1'b1;
            default: begin
                if (p.wide) h = ((32'(p.addr) >> 1) == (idx >> 1));
                else        h = (32'(p.addr) == idx);
            end
        endcase
        return h;
    endfunction

    // byte value written; even byte holds the upper half of a word
    function automatic logic [7:0] mw_val(mw_prog_t p, logic odd);
        logic [7:0] v;
        case (p.kind)
            PK_CLR, PK_WIPE: v = 8'hFF;
            default: v = (p.wide && !odd) ? p.data[15:8] : p.data[7:0];
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~prev;
    assign fall  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (start)       left <= CW'(CYCLES);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int BYTES = 1024,
    parameter int ABW   = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  mw_prog_t           req,
    input  logic [ABW-1:0]     rd_addr,
    output logic [MW_WORD-1:0] rd_pair,
    output logic [7:0]         rd_byte
);
    logic [7:0] cells [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTES; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            for (int i = 0; i < BYTES; i++) begin
                if (mw_hit(req, i)) cells[i] <= mw_val(req, i[0]);
            end
        end
    end

    assign rd_pair = {cells[{rd_addr[ABW-1:1], 1'b0}], cells[{rd_addr[ABW-1:1], 1'b1}]};
    assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int ABW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_lvl,
    input  logic               cs_fall,
    input  logic               sk_rise,
    input  logic               sk_fall,
    input  logic               di_lvl,
    input  logic               wide,
    input  logic               busy,
    input  logic [MW_WORD-1:0] rd_pair,
    input  logic [7:0]         rd_byte,
    output logic [ABW-1:0]     rd_addr,
    output logic               prog_go,
    output mw_prog_t           prog_req,
    output logic               ser_out,
    output logic               ser_oe,
    output logic               wen,
    output logic               stat_flag,
    output logic               rd_active
);
    localparam int HW = ABW + 3;
    localparam int CW = $clog2(HW + MW_WORD);
    localparam int PW = $clog2(MW_WORD);

    mw_state_e          state;
    logic [CW-1:0]      cnt;
    logic [HW-1:0]      hdr;
    logic [MW_WORD-1:0] dat;
    logic [PW-1:0]      pos;
    logic               do_q;
    logic               rel_pend;
    mw_prog_t           pend;

    logic [HW-1:0]      hdr_nx;
    logic [MW_WORD-1:0] dat_nx;
    logic [CW-1:0]      hdr_end;
    logic [CW-1:0]      dat_end;
    mw_opc_e            opc;
    mw_sub_e            sub;
    logic [ABW-1:0]     baddr;
    logic [MW_WORD-1:0] cur_word;
    logic [PW-1:0]      pos_top;

    always_comb begin
        hdr_nx   = {hdr[HW-2:0], di_lvl};
        dat_nx   = {dat[MW_WORD-2:0], di_lvl};
        hdr_end  = wide ? CW'(ABW + 1) : CW'(ABW + 2);
        dat_end  = wide ? CW'(MW_WORD - 1) : CW'(MW_WORD / 2 - 1);
        pos_top  = wide ? PW'(MW_WORD - 1) : PW'(MW_WORD / 2 - 1);
        if (wide) begin
            opc   = mw_opc_e'(hdr_nx[ABW+1:ABW]);
            sub   = mw_sub_e'(hdr_nx[ABW-1:ABW-2]);
            baddr = {hdr_nx[ABW-2:0], 1'b0};
        end else begin
            opc   = mw_opc_e'(hdr_nx[ABW+2:ABW+1]);
            sub   = mw_sub_e'(hdr_nx[ABW:ABW-1]);
            baddr = hdr_nx[ABW-1:0];
        end
        cur_word = wide ? rd_pair : {8'h00, rd_byte};
    end

    assign prog_go = cs_fall && (state == ST_ARMED) && wen && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            hdr       <= '0;
            dat       <= '0;
            pos       <= '0;
            do_q      <= 1'b0;
            rel_pend  <= 1'b0;
            wen       <= 1'b0;
            stat_flag <= 1'b0;
            rd_addr   <= '0;
            pend      <= '0;
        end else begin
            if (!cs_lvl) begin
                state    <= ST_IDLE;
                rel_pend <= 1'b0;
            end else if (!busy) begin
                if (sk_rise) begin
                    case (state)
                        ST_IDLE: begin
                            if (di_lvl) begin
                                state <= ST_HDR;
                                cnt   <= '0;
                                hdr   <= '0;
                                if (stat_flag) rel_pend <= 1'b1;
                            end
                        end
                        ST_HDR: begin
                            hdr <= hdr_nx;
                            cnt <= cnt + 1'b1;
                            if (cnt == hdr_end) begin
                                cnt <= '0;
                                dat <= '0;
                                pend.wide <= wide;
                                pend.addr <= MW_AW_MAX'(baddr);
                                pend.data <= '0;
                                case (opc)
                                    OPC_READ: begin
                                        state   <= ST_READ;
                                        rd_addr <= baddr;
                                        pos     <= pos_top;
                                        do_q    <= 1'b0;
                                    end
                                    OPC_WRITE: begin
                                        pend.kind <= PK_ONE;
                                        state     <= ST_DATA;
                                    end
                                    OPC_ERASE: begin
                                        pend.kind <= PK_CLR;
                                        state     <= ST_ARMED;
                                    end
                                    default: begin
                                        case (sub)
                                            SUB_UNLOCK: begin
                                                wen   <= 1'b1;
                                                state <= ST_HOLD;
                                            end
                                            SUB_LOCK: begin
                                                wen   <= 1'b0;
                                                state <= ST_HOLD;
                                            end
                                            SUB_WIPE: begin
                                                pend.kind <= PK_WIPE;
                                                state     <= ST_ARMED;
                                            end
                                            default: begin
                                                pend.kind <= PK_FILL;
                                                state     <= ST_DATA;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                        ST_DATA: begin
                            dat <= dat_nx;
                            cnt <= cnt + 1'b1;
                            if (cnt == dat_end) begin
                                pend.data <= wide ? dat_nx : {8'h00, dat_nx[7:0]};
                                state     <= ST_ARMED;
                            end
                        end
                        ST_READ: begin
                            do_q <= cur_word[pos];
                            if (pos == '0) begin
                                pos     <= pos_top;
                                rd_addr <= rd_addr + (wide ? ABW'(2) : ABW'(1));
                            end else begin
                                pos <= pos - 1'b1;
                            end
                        end
                        ST_ARMED: state <= ST_HOLD;
                        default: ;
                    endcase
                end
                if (sk_fall && rel_pend) begin
                    stat_flag <= 1'b0;
                    rel_pend  <= 1'b0;
                end
            end
            if (prog_go) stat_flag <= 1'b1;
        end
    end

    assign prog_req  = pend;
    assign rd_active = (state == ST_READ);
    assign ser_oe    = cs_lvl && (stat_flag || rd_active);
    assign ser_out   = stat_flag ? !busy : do_q;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    input  logic wide_org,
    output logic ser_out,
    output logic ser_oe
);
    localparam int ABW = $clog2(MEM_BYTES);

    logic [2:0]         lvl_v;
    logic [2:0]         rise_v;
    logic [2:0]         fall_v;
    logic               cs_lvl;
    logic               busy;
    logic               prog_go;
    mw_prog_t           prog_req;
    logic [ABW-1:0]     rd_addr;
    logic [MW_WORD-1:0] rd_pair;
    logic [7:0]         rd_byte;
    logic               wen;
    logic               stat_flag;
    logic               rd_active;
    logic               unused_edges;

    mw_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({chip_sel, ser_clk, ser_in}),
        .level (lvl_v),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    assign cs_lvl       = lvl_v[2];
    assign unused_edges = ^{rise_v[2], rise_v[0], fall_v[0], lvl_v[1]};

    mw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_go),
        .busy  (busy)
    );

    mw_store #(.BYTES(MEM_BYTES), .ABW(ABW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (prog_go),
        .req     (prog_req),
        .rd_addr (rd_addr),
        .rd_pair (rd_pair),
        .rd_byte (rd_byte)
    );

    mw_ctrl #(.ABW(ABW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_lvl    (cs_lvl),
        .cs_fall   (fall_v[2]),
        .sk_rise   (rise_v[1]),
        .sk_fall   (fall_v[1]),
        .di_lvl    (lvl_v[0]),
        .wide      (wide_org),
        .busy      (busy),
        .rd_pair   (rd_pair),
        .rd_byte   (rd_byte),
        .rd_addr   (rd_addr),
        .prog_go   (prog_go),
        .prog_req  (prog_req),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe),
        .wen       (wen),
        .stat_flag (stat_flag),
        .rd_active (rd_active)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int CYCLES = 5000
) (
    input logic clk,
    input logic rst,
    input logic cs_lvl,
    input logic busy,
    input logic prog_go,
    input logic wen,
    input logic rd_active,
    input logic ser_out,
    input logic ser_oe
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)          busy_cnt <= 0;
        else if (prog_go) busy_cnt <= 0;
        else if (busy)    busy_cnt <= busy_cnt + 1;
    end

    // R12: output released whenever the device is deselected
    p_quiet_deselect_r12: assert property (@(posedge clk) disable iff (rst)
        !cs_lvl |-> !ser_oe);

    // R8: a program cycle is only launched with select already low
    p_go_while_low_r8: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> !cs_lvl);

    // R9: a launch makes the device busy on the next cycle
    p_go_starts_busy_r9: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> busy);

    // R9: busy lasts exactly the programmed number of cycles
    p_busy_length_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == CYCLES));

    // R11: lock state cannot change during a program cycle
    p_wen_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wen));

    // R5: only an unlocked device starts a program cycle
    p_locked_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wen);

    // R3: a read opens with a driven zero
    p_dummy_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_active) |-> (ser_oe && !ser_out));
endmodule

bind mw_eeprom mw_eeprom_chk #(.CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (cs_lvl),
    .busy      (busy),
    .prog_go   (prog_go),
    .wen       (wen),
    .rd_active (rd_active),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 400;
    localparam int SKH        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_sel = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_in = 1'b0;
    logic wide_org = 1'b1;
    logic ser_out;
    logic ser_oe;

    int total = 0;
    int bad = 0;
    int mon_total = 0;
    int mon_bad = 0;
    int low_run = 0;
    bit done = 1'b0;

    logic [15:0] r16 [512];
    logic [7:0]  r8  [1024];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_eeprom #(.MEM_BYTES(1024), .PROG_CYCLES(PROG)) dut (
        .clk      (clk),
        .rst      (rst),
        .chip_sel (chip_sel),
        .ser_clk  (ser_clk),
        .ser_in   (ser_in),
        .wide_org (wide_org),
        .ser_out  (ser_out),
        .ser_oe   (ser_oe)
    );

    // per-clock reference: deselected for a few cycles means released output (R12)
    always @(negedge clk) begin
        if (!rst) begin
            if (!chip_sel) low_run++;
            else low_run = 0;
            if (low_run >= 4) begin
                mon_total++;
                if (ser_oe) begin
                    mon_bad++;
                    $display("FAIL R12 monitor actual oe=%0b expected oe=0", ser_oe);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int aw();
        return wide_org ? 10 : 11;
    endfunction

    task automatic pulse(input logic b);
        ser_in = b;
        repeat (SKH) @(negedge clk);
        ser_clk = 1'b1;
        repeat (SKH) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send(input int val, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(val[i]);
    endtask

    task automatic begin_cmd(input int opc, input int addr, input int lead);
        chip_sel = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < lead; i++) pulse(1'b0);
        pulse(1'b1);
        send(opc, 2);
        send(addr, aw());
    endtask

    task automatic cs_done();
        @(negedge clk);
        ser_in = 1'b0;
        chip_sel = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic special(input int sel);
        begin_cmd(0, sel << (aw() - 2), 0);
        cs_done();
    endtask

    task automatic prog_wait(input bit expect_busy, input string req);
        chip_sel = 1'b1;
        repeat (6) @(negedge clk);
        if (expect_busy) begin
            chk({req, " R9 busy"}, {ser_oe, ser_out}, 2'b10);
            repeat (PROG) @(negedge clk);
            chk({req, " R9 ready"}, {ser_oe, ser_out}, 2'b11);
            pulse(1'b1);
            repeat (6) @(negedge clk);
            chk({req, " R10 release"}, ser_oe, 1'b0);
        end else begin
            chk({req, " no cycle"}, ser_oe, 1'b0);
        end
        cs_done();
    endtask

    task automatic read_seq(input int a, input int n, input int lead, input string req);
        int depth;
        int wbits;
        int idx;
        logic [15:0] got;
        logic [15:0] exp;
        depth = wide_org ? 512 : 1024;
        wbits = wide_org ? 16 : 8;
        idx = a & (depth - 1);
        begin_cmd(2, a, lead);
        repeat (2) @(negedge clk);
        chk({req, " R3 dummy"}, {ser_oe, ser_out}, 2'b10);
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = 0; b < wbits; b++) begin
                pulse(1'b0);
                repeat (2) @(negedge clk);
                got = {got[14:0], ser_out};
            end
            exp = wide_org ? r16[idx] : {8'h00, r8[idx]};
            chk(req, got, exp);
            idx = (idx + 1) % depth;
        end
        cs_done();
    endtask

    task automatic write16(input int a, input int d);
        begin_cmd(1, a, 0);
        send(d, 16);
        cs_done();
    endtask

    initial begin
        for (int i = 0; i < 512; i++) r16[i] = 16'hFFFF;
        for (int i = 0; i < 1024; i++) r8[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe after reset", ser_oe, 1'b0);
        read_seq(0, 2, 0, "R1 erased");

        // locked write is dropped
        write16(5, 16'h1234);
        prog_wait(1'b0, "R5 locked");
        read_seq(5, 1, 0, "R5 unchanged");

        special(3);
        write16(5, 16'hA5C3);
        r16[5] = 16'hA5C3;
        // clock a full write while busy: must be ignored
        chip_sel = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 busy", {ser_oe, ser_out}, 2'b10);
        pulse(1'b1);
        send(1, 2);
        send(6, 10);
        send(16'hDEAD, 16);
        cs_done();
        repeat (PROG) @(negedge clk);
        chip_sel = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 ready", {ser_oe, ser_out}, 2'b11);
        pulse(1'b1);
        repeat (6) @(negedge clk);
        chk("R10 release", ser_oe, 1'b0);
        cs_done();
        read_seq(5, 2, 0, "R6 R11 write and ignored");

        write16(511, 16'h0BEE);
        r16[511] = 16'h0BEE;
        prog_wait(1'b1, "R6 top");
        write16(0, 16'h1357);
        r16[0] = 16'h1357;
        prog_wait(1'b1, "R6 base");
        read_seq(510, 4, 2, "R4 R2 wrap");
        read_seq(512 | 511, 1, 0, "R2 msb ignored");

        // late fall: an extra rising edge after the last bit
        begin_cmd(1, 7, 0);
        send(16'h7777, 16);
        pulse(1'b0);
        cs_done();
        prog_wait(1'b0, "R8 late");
        // early fall: one data bit short
        begin_cmd(1, 7, 0);
        send(16'h7777 >> 1, 15);
        cs_done();
        prog_wait(1'b0, "R8 early");
        read_seq(7, 1, 0, "R8 unchanged");

        begin_cmd(3, 5, 0);
        cs_done();
        r16[5] = 16'hFFFF;
        prog_wait(1'b1, "R7 erase");
        read_seq(4, 2, 0, "R7 erase");

        begin_cmd(0, 1 << 8, 0);
        send(16'h6C39, 16);
        cs_done();
        for (int i = 0; i < 512; i++) r16[i] = 16'h6C39;
        prog_wait(1'b1, "R7 fill");
        read_seq(300, 2, 0, "R7 fill");

        special(2);
        for (int i = 0; i < 512; i++) r16[i] = 16'hFFFF;
        prog_wait(1'b1, "R7 wipe");
        read_seq(511, 2, 0, "R7 wipe");

        special(0);
        write16(2, 16'h4242);
        prog_wait(1'b0, "R5 relocked");
        read_seq(2, 1, 0, "R5 relocked");

        // byte organization
        wide_org = 1'b0;
        repeat (4) @(negedge clk);
        special(3);
        begin_cmd(1, 1023, 0);
        send(8'h5A, 8);
        cs_done();
        r8[1023] = 8'h5A;
        prog_wait(1'b1, "R6 byte top");
        begin_cmd(1, 0, 0);
        send(8'hC3, 8);
        cs_done();
        r8[0] = 8'hC3;
        prog_wait(1'b1, "R6 byte base");
        read_seq(1023, 3, 0, "R4 byte wrap");
        read_seq(1024 | 1023, 1, 0, "R2 byte msb ignored");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end
endmodule